// File: doc/BRIEF.md
# Idle-Channel Auto-Mute Detector

This block decides when a stereo digital audio path should be silenced because its input has gone idle. On every frame boundary it receives one left and one right sample word, together with a one-cycle frame strobe. It sorts each word into one of two classes. A word is idle when all its bits are equal, meaning all zeros or all ones. Otherwise the word is live. It then keeps count of how many frames in a row had both channels idle.

Once that run reaches a configurable frame count (8192 by default), a single mute flag covering both channels is raised. The first frame that carries live data on either channel drops the flag again in the same update. That same frame also restarts the run from zero.

An active-low enable input gates the whole function. While the enable input is high, the flag stays low and the run count is held at zero. Sample deserialisation, gain ramps and analogue muting sit outside this block. Downstream logic uses only the flag.

Top module: `idle_mute_detector`

## Requirements
- R1: A synchronous active-high reset leaves `mute_o` low on the cycle after reset and clears the idle-run count.
- R2: A frame is idle only if both sample words are each all zeros or all ones. The two channels may differ, for example left all zeros and right all ones. A frame in which either word has mixed bits is not idle and restarts the run.
- R3: With `enable_n` low, `mute_o` rises on the clock edge that captures the `IDLE_FRAMES`-th consecutive idle frame. It is still low after `IDLE_FRAMES`-1 such frames.
- R4: A non-idle word on either channel, captured on a strobe edge, drives `mute_o` low on that same edge.
- R5: A non-idle frame clears the run count to zero. A full `IDLE_FRAMES` further idle frames are then needed before mute rises again.
- R6: While idle frames continue, the run count saturates. `mute_o` stays high for any number of idle frames past the threshold and never drops because the count wraps.
- R7: While `enable_n` is high, `mute_o` never rises. Raising `enable_n` while muted clears `mute_o` and the count on the next strobe edge, not earlier.
- R8: On cycles with `frame_stb` low, the sample inputs are ignored and `mute_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle pulse marking a new stereo frame |
| left_smp | input | SAMPLE_W | Left sample word, valid with `frame_stb` |
| right_smp | input | SAMPLE_W | Right sample word, valid with `frame_stb` |
| enable_n | input | 1 | Auto-mute enable, active low |
| mute_o | output | 1 | Mute request covering both channels |

## Verification
The bench targets the off-by-one edge of the threshold. It looks for mute after exactly `IDLE_FRAMES` idle frames and not after one fewer, which catches a comparator or counter reset that is one frame off. It runs more than twice the counter's natural range of idle frames, because a counter that wraps instead of saturating would drop mute partway through. It checks release on each channel separately, and it checks a frame where only one channel is idle; a design that tests one channel only, or that needs both channels live to release, fails those checks. It also checks that mute does not return after a shortened run, which exposes a counter that is not cleared on release. Finally it checks that raising enable is honoured only at a strobe, that it clears the count, and that samples changed between strobes are ignored.

// File: rtl/idle_mute_pkg.sv
package idle_mute_pkg;

    localparam int unsigned DEF_SAMPLE_W   = 20;
    localparam int unsigned DEF_IDLE_FRAMES = 8192;

    // Per-frame classification of the two channels
    typedef struct packed {
        logic left_idle;
        logic right_idle;
    } frame_class_t;

    // Control state of the mute decision
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,   // function disabled
        ST_WATCH = 2'd1,   // enabled, counting idle frames
        ST_MUTED = 2'd2    // idle run reached threshold
    } mute_state_t;

    function automatic logic frame_is_idle(frame_class_t fc);
        return fc.left_idle & fc.right_idle;
    endfunction

endpackage

// File: rtl/idle_word_detect.sv
module idle_word_detect #(
    parameter int unsigned WIDTH = 20
) (
    input  logic [WIDTH-1:0] word_i,
    output logic             idle_o
);
    logic all_zero;
    logic all_one;

    always_comb begin
        all_zero = ~|word_i;
        all_one  = &word_i;
        idle_o   = all_zero | all_one;
    end
endmodule

// File: rtl/idle_run_counter.sv
module idle_run_counter #(
    parameter int unsigned LIMIT = 8192,
    localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance_i,
    input  logic             clear_i,
    output logic             near_full_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            count_q <= '0;
        end else if (advance_i && (count_q != CNT_MAX)) begin
            count_q <= count_q + 1'b1;
        end
    end

    // The frame now being captured would complete the run
    always_comb near_full_o = (count_q >= CNT_LAST);
endmodule

// File: rtl/mute_ctrl.sv
module mute_ctrl
    import idle_mute_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_stb,
    input  logic         enable_n,
    input  frame_class_t fclass_i,
    input  logic         run_full_i,
    output logic         cnt_advance_o,
    output logic         cnt_clear_o,
    output logic         mute_o
);
    mute_state_t state_q, state_d;
    logic        idle_frame;

    always_comb begin
        idle_frame    = frame_is_idle(fclass_i);
        cnt_advance_o = frame_stb && !enable_n && idle_frame;
        cnt_clear_o   = frame_stb && (enable_n || !idle_frame);
        state_d       = state_q;
        if (frame_stb) begin
            if (enable_n) begin
                state_d = ST_OFF;
            end else if (!idle_frame) begin
                state_d = ST_WATCH;
            end else if (run_full_i) begin
                state_d = ST_MUTED;
            end else begin
                state_d = ST_WATCH;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    always_comb mute_o = (state_q == ST_MUTED);
endmodule

// File: rtl/idle_mute_detector.sv
module idle_mute_detector
    import idle_mute_pkg::*;
#(
    parameter int unsigned SAMPLE_W    = DEF_SAMPLE_W,
    parameter int unsigned IDLE_FRAMES = DEF_IDLE_FRAMES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_stb,
    input  logic [SAMPLE_W-1:0] left_smp,
    input  logic [SAMPLE_W-1:0] right_smp,
    input  logic                enable_n,
    output logic                mute_o
);
    localparam int unsigned NUM_CH = 2;

    logic [SAMPLE_W-1:0] ch_word [NUM_CH];
    logic [NUM_CH-1:0]   ch_idle;
    frame_class_t        fclass;
    logic                run_full;
    logic                cnt_adv;
    logic                cnt_clr;

    always_comb begin
        ch_word[0] = left_smp;
        ch_word[1] = right_smp;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        idle_word_detect #(.WIDTH(SAMPLE_W)) u_det (
            .word_i (ch_word[c]),
            .idle_o (ch_idle[c])
        );
    end

    always_comb begin
        fclass.left_idle  = ch_idle[0];
        fclass.right_idle = ch_idle[1];
    end

    idle_run_counter #(.LIMIT(IDLE_FRAMES)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .advance_i   (cnt_adv),
        .clear_i     (cnt_clr),
        .near_full_o (run_full)
    );

    mute_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .frame_stb     (frame_stb),
        .enable_n      (enable_n),
        .fclass_i      (fclass),
        .run_full_i    (run_full),
        .cnt_advance_o (cnt_adv),
        .cnt_clear_o   (cnt_clr),
        .mute_o        (mute_o)
    );
endmodule

// File: rtl/idle_mute_checker.sv
module idle_mute_checker #(
    parameter int unsigned SAMPLE_W = 20
) (
    input logic                clk,
    input logic                rst,
    input logic                frame_stb,
    input logic [SAMPLE_W-1:0] left_smp,
    input logic [SAMPLE_W-1:0] right_smp,
    input logic                enable_n,
    input logic                mute_o
);
    logic l_live, r_live;
    always_comb begin
        l_live = !((&left_smp) || !(|left_smp));
        r_live = !((&right_smp) || !(|right_smp));
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> !mute_o);

    // R3
    rise_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mute_o) |-> ($past(frame_stb) && !$past(enable_n)));

    // R4
    live_release_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && (l_live || r_live)) |=> !mute_o);

    // R6
    hold_while_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mute_o && frame_stb && !enable_n && !l_live && !r_live) |=> mute_o);

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && enable_n) |=> !mute_o);

    // R8
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(mute_o));
endmodule

bind idle_mute_detector idle_mute_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .left_smp  (left_smp),
    .right_smp (right_smp),
    .enable_n  (enable_n),
    .mute_o    (mute_o)
);

// File: tb/idle_mute_detector_bench.sv
module idle_mute_detector_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 20;
    localparam int N = 8192;
    localparam logic [W-1:0] ZEROS = '0;
    localparam logic [W-1:0] ONES  = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         frame_stb = 1'b0;
    logic [W-1:0] left_smp = '0;
    logic [W-1:0] right_smp = '0;
    logic         enable_n = 1'b0;
    logic         mute_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idle_mute_detector #(.SAMPLE_W(W), .IDLE_FRAMES(N)) u_idle_mute_detector (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .left_smp  (left_smp),
        .right_smp (right_smp),
        .enable_n  (enable_n),
        .mute_o    (mute_o)
    );

    task automatic check(string req, logic exp);
        total++;
        if (mute_o !== exp) begin
            bad++;
            $display("FAIL %s: mute_o=%b expected=%b at %0t", req, mute_o, exp, $time);
        end
    endtask

    // Strobe n idle frames back to back, varying the idle patterns
    task automatic idle_frames(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_stb = 1'b1;
            left_smp  = (i % 3 == 1) ? ONES : ZEROS;
            right_smp = (i % 2 == 1) ? ONES : ZEROS;
        end
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic one_frame(logic [W-1:0] l, logic [W-1:0] r);
        @(negedge clk);
        frame_stb = 1'b1; left_smp = l; right_smp = r;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 after reset", 1'b0);
    endtask

    task automatic t_threshold;
        idle_frames(N - 1);
        check("R3 one frame short", 1'b0);
        idle_frames(1);
        check("R3 threshold reached", 1'b1);
    endtask

    task automatic t_saturate;
        idle_frames(2 * N + 100);
        check("R6 saturate past wrap point", 1'b1);
    endtask

    task automatic t_gap;
        @(negedge clk);
        left_smp = 20'h5A5A5; right_smp = 20'h12345;
        repeat (4) @(negedge clk);
        check("R8 no strobe ignored", 1'b1);
    endtask

    task automatic t_release_left;
        one_frame(20'h00001, ZEROS);
        check("R4 left live releases", 1'b0);
        idle_frames(N - 1);
        check("R5 count cleared after release", 1'b0);
        idle_frames(1);
        check("R5 full run remutes", 1'b1);
    endtask

    task automatic t_release_right;
        one_frame(ONES, 20'hFFFFE);
        check("R4 right live releases", 1'b0);
    endtask

    task automatic t_partial;
        idle_frames(N - 1);
        one_frame(ZEROS, 20'h55555);
        check("R2 one-sided idle frame", 1'b0);
        idle_frames(N - 1);
        check("R2 run restarted by partial frame", 1'b0);
        one_frame(ZEROS, ONES);
        check("R2 mixed idle patterns count", 1'b1);
    endtask

    task automatic t_enable;
        @(negedge clk); enable_n = 1'b1;
        one_frame(20'h00010, ZEROS);
        idle_frames(N + 10);
        check("R7 disabled never mutes", 1'b0);
        @(negedge clk); enable_n = 1'b0;
        idle_frames(N);
        check("R7 remute after enable", 1'b1);
        @(negedge clk); enable_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 waits for strobe", 1'b1);
        one_frame(ZEROS, ZEROS);
        check("R7 cleared at strobe", 1'b0);
        @(negedge clk); enable_n = 1'b0;
        idle_frames(N - 1);
        check("R7 count cleared by disable", 1'b0);
        idle_frames(1);
        check("R7 full run after disable", 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: expired actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_threshold();
        t_saturate();
        t_gap();
        t_release_left();
        t_release_right();
        t_partial();
        t_enable();
        t_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule